// File: doc/BRIEF.md
# Ethernet Receive Frame Queue

This block holds incoming Ethernet frames in a ring of frame slots until software drains them. Frames arrive on a byte-stream input with start and end markers. The block stores each frame in the next free slot as a 16-bit little-endian length, the frame bytes, and a 4-byte CRC that another block supplies on an input port. The stored record is zero-filled to a whole 32-bit word. Address filtering and physical-layer decoding belong to other blocks.

Software reads the oldest frame one 32-bit word at a time through a data register. The byte at the lowest offset comes back in bits 7:0. After the last word of a frame has been read, the ring moves to the next slot on its own. A count register shows how many frames are waiting. Two status bits report a queued frame and an oversize discard. The interrupt line is the masked OR of the status bits. The slot count and the slot size are parameters. The default slot size is kept small so that elaboration stays cheap, and 2048 bytes is the full-size setting.

Top module: `eth_rx_frame_queue`

## Requirements
- R1: After reset the status reads 0, the mask reads 0x7F (all seven sources enabled), the control register reads 0, the frame count reads 0 and irq is low.
- R2: A frame is stored only if, on its first byte, the enable bit (control bit 0) is 1 and fewer than SLOTS frames are pending. Any other frame is dropped without setting a status bit.
- R3: A stored frame of N bytes reads back as these bytes in this order: N+6 as a 16-bit little-endian value, the N data bytes, rx_crc (sampled with the last byte) with its low byte first, then zeros up to a word boundary. Each data read packs four bytes, with the lowest offset in bits 7:0.
- R4: A frame with N >= SLOT_BYTES-6 is discarded, leaves the count unchanged and sets status bit 3. A frame with N = SLOT_BYTES-7 is stored in full.
- R5: Each data read with a frame pending advances the read offset by 4. Once the offset reaches the stored length, the offset returns to 0, the next slot becomes the head and the count drops by 1.
- R6: Slots are used in ring order modulo SLOTS and frames come out in arrival order. Up to SLOTS frames can be pending at once, and the count never exceeds SLOTS.
- R7: A data read with no frame pending changes neither the count nor the read position.
- R8: Writing the control register with bit 1 set clears the count and the read offset, and abandons any frame being stored.
- R9: Each stored frame sets status bit 0. Writing 1 to a status bit clears it.
- R10: irq is the registered OR of status AND mask. With a zero mask, irq stays low.
- R11: Register word addresses are: 0 status (read) / clear (write), 1 mask, 2 control, 3 data, 4 frame count. Read data appears on the cycle after reg_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Byte on rx_data is valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Frame byte |
| rx_crc | input | 32 | CRC value for the frame, sampled with the last byte |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid one cycle after reg_rd |
| irq | output | 1 | Interrupt request |

## Verification
The assertions rely on the sender leaving at least 12 idle cycles after a frame's last byte, because the block spends up to nine cycles writing the CRC, the padding and the length. They also assume that no start marker appears inside a frame and that reg_rd and reg_wr are never high together. The bench drives each frame as an unbroken run of bytes with sixteen idle cycles after it. It issues register accesses one at a time, so the stream and the register port never overlap. Random frame sizes run past the discard limit, so stores, discards and full-ring drops are all mixed in with reads.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned NUM_SRC    = 7;
  localparam int unsigned ST_RX_BIT  = 0;
  localparam int unsigned ST_OVF_BIT = 3;

  localparam logic [2:0] A_STAT = 3'd0;
  localparam logic [2:0] A_MASK = 3'd1;
  localparam logic [2:0] A_CTRL = 3'd2;
  localparam logic [2:0] A_DATA = 3'd3;
  localparam logic [2:0] A_CNT  = 3'd4;

  typedef enum logic [2:0] {
    W_IDLE, W_RECV, W_DROP, W_TAIL, W_LEN0, W_LEN1
  } wr_state_e;
endpackage

// File: rtl/rxq_mem.sv
module rxq_mem #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [3:0]    be,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wbyte,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] ram [0:DEPTH-1];
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (we && be[l]) ram[waddr] <= wbyte;
      q <= ram[raddr];
    end
    assign rdata[8*l +: 8] = q;
  end
endmodule

// File: rtl/rxq_writer.sv
module rxq_writer
  import rxq_pkg::*;
#(
  parameter int SLOTS      = 31,
  parameter int SLOT_BYTES = 128,
  localparam int SW = $clog2(SLOTS),
  localparam int BW = $clog2(SLOT_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          rx_en,
  input  logic          ring_full,
  input  logic [SW-1:0] free_slot,
  input  logic          rx_valid,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic [7:0]    rx_data,
  input  logic [31:0]   rx_crc,
  output logic          wr_en,
  output logic [SW-1:0] wr_slot,
  output logic [BW-1:0] wr_off,
  output logic [7:0]    wr_byte,
  output logic          commit,
  output logic [SW-1:0] commit_slot,
  output logic [BW-1:0] commit_len,
  output logic          ovf
);
  localparam logic [BW-1:0] LIM = BW'(SLOT_BYTES - 6);

  wr_state_e     st;
  logic [SW-1:0] slot_q;
  logic [BW-1:0] cnt;
  logic [31:0]   crc_q;
  logic [2:0]    idx;

  logic          accept_start;
  logic [BW-1:0] cnt_inc;
  logic [1:0]    pad;
  logic [2:0]    tail_last;
  logic [15:0]   len16;
  logic          too_big;

  assign accept_start = rx_valid && rx_sof && rx_en && !ring_full;
  assign cnt_inc      = (cnt < LIM) ? cnt + BW'(1) : cnt;
  assign too_big      = cnt_inc >= LIM;
  assign pad          = 2'd2 - cnt[1:0];
  assign tail_last    = 3'd3 + {1'b0, pad};
  assign commit_len   = cnt + BW'(6);
  assign len16        = 16'(commit_len);
  assign wr_slot      = (st == W_IDLE) ? free_slot : slot_q;
  assign commit_slot  = slot_q;

  always_comb begin
    wr_en   = 1'b0;
    wr_off  = '0;
    wr_byte = rx_data;
    commit  = 1'b0;
    ovf     = 1'b0;
    unique case (st)
      W_IDLE: if (accept_start) begin
        wr_en  = 1'b1;
        wr_off = BW'(2);
      end
      W_RECV: if (rx_valid) begin
        if (cnt < LIM) begin
          wr_en  = 1'b1;
          wr_off = cnt + BW'(2);
        end
        if (rx_eof && too_big) ovf = 1'b1;
      end
      W_TAIL: begin
        wr_en  = 1'b1;
        wr_off = cnt + BW'(2) + BW'(idx);
        case (idx)
          3'd0:    wr_byte = crc_q[7:0];
          3'd1:    wr_byte = crc_q[15:8];
          3'd2:    wr_byte = crc_q[23:16];
          3'd3:    wr_byte = crc_q[31:24];
          default: wr_byte = 8'h00;
        endcase
      end
      W_LEN0: begin
        wr_en   = 1'b1;
        wr_off  = '0;
        wr_byte = len16[7:0];
      end
      W_LEN1: begin
        wr_en   = 1'b1;
        wr_off  = BW'(1);
        wr_byte = len16[15:8];
        commit  = 1'b1;
      end
      default: ;
    endcase
    if (flush) begin
      wr_en  = 1'b0;
      commit = 1'b0;
      ovf    = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      st  <= W_IDLE;
      idx <= '0;
      cnt <= '0;
    end else begin
      unique case (st)
        W_IDLE: if (rx_valid && rx_sof) begin
          if (accept_start) begin
            slot_q <= free_slot;
            cnt    <= BW'(1);
            if (rx_eof) begin
              crc_q <= rx_crc;
              idx   <= '0;
              st    <= W_TAIL;
            end else begin
              st <= W_RECV;
            end
          end else if (!rx_eof) begin
            st <= W_DROP;
          end
        end
        W_RECV: if (rx_valid) begin
          cnt <= cnt_inc;
          if (rx_eof) begin
            if (too_big) begin
              st <= W_IDLE;
            end else begin
              crc_q <= rx_crc;
              idx   <= '0;
              st    <= W_TAIL;
            end
          end
        end
        W_DROP: if (rx_valid && rx_eof) st <= W_IDLE;
        W_TAIL: begin
          if (idx == tail_last) st <= W_LEN0;
          else idx <= idx + 3'd1;
        end
        W_LEN0: st <= W_LEN1;
        W_LEN1: st <= W_IDLE;
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxq_ring.sv
module rxq_ring #(
  parameter int SLOTS      = 31,
  parameter int SLOT_BYTES = 128,
  localparam int SW = $clog2(SLOTS),
  localparam int CW = $clog2(SLOTS + 1),
  localparam int BW = $clog2(SLOT_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          commit,
  input  logic [SW-1:0] commit_slot,
  input  logic [BW-1:0] commit_len,
  input  logic          pop_req,
  output logic [SW-1:0] head,
  output logic [CW-1:0] pending,
  output logic [BW-1:0] rd_off,
  output logic [SW-1:0] free_slot,
  output logic          full
);
  logic [BW-1:0] len_tbl [0:SLOTS-1];
  logic          pop, done;
  logic [BW:0]   off_next;
  logic [SW:0]   sum;

  assign pop      = pop_req && (pending != '0);
  assign off_next = {1'b0, rd_off} + (BW+1)'(4);
  assign done     = off_next >= {1'b0, len_tbl[head]};
  assign sum      = {1'b0, head} + (SW+1)'(pending);
  assign free_slot = (sum >= (SW+1)'(SLOTS)) ? SW'(sum - (SW+1)'(SLOTS)) : SW'(sum);
  assign full     = pending == CW'(SLOTS);

  always_ff @(posedge clk) begin
    if (commit) len_tbl[commit_slot] <= commit_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head    <= '0;
      pending <= '0;
      rd_off  <= '0;
    end else if (flush) begin
      pending <= '0;
      rd_off  <= '0;
    end else begin
      if (pop) begin
        if (done) begin
          rd_off <= '0;
          head   <= (head == SW'(SLOTS - 1)) ? '0 : head + SW'(1);
        end else begin
          rd_off <= off_next[BW-1:0];
        end
      end
      pending <= pending + CW'(commit) - CW'(pop && done);
    end
  end
endmodule

// File: rtl/eth_rx_frame_queue.sv
module eth_rx_frame_queue
  import rxq_pkg::*;
#(
  parameter int SLOTS      = 31,
  parameter int SLOT_BYTES = 128
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic [7:0]  rx_data,
  input  logic [31:0] rx_crc,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam int SW = $clog2(SLOTS);
  localparam int CW = $clog2(SLOTS + 1);
  localparam int BW = $clog2(SLOT_BYTES);
  localparam int WW = BW - 2;
  localparam int AW = SW + WW;

  logic [NUM_SRC-1:0] status, mask;
  logic               rx_en;
  logic               flush, pop_req;

  logic [SW-1:0] head, free_slot, wr_slot, commit_slot;
  logic [CW-1:0] pending;
  logic [BW-1:0] rd_off, wr_off, commit_len;
  logic          full, wr_en, commit, ovf;
  logic [7:0]    wr_byte;
  logic [31:0]   mem_q, other_q;
  logic          sel_data_q;

  assign flush   = reg_wr && (reg_addr == A_CTRL) && reg_wdata[1];
  assign pop_req = reg_rd && (reg_addr == A_DATA);

  rxq_writer #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_writer (
    .clk(clk), .rst(rst), .flush(flush), .rx_en(rx_en), .ring_full(full),
    .free_slot(free_slot), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .rx_crc(rx_crc),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_off(wr_off), .wr_byte(wr_byte),
    .commit(commit), .commit_slot(commit_slot), .commit_len(commit_len),
    .ovf(ovf)
  );

  rxq_ring #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_ring (
    .clk(clk), .rst(rst), .flush(flush), .commit(commit),
    .commit_slot(commit_slot), .commit_len(commit_len), .pop_req(pop_req),
    .head(head), .pending(pending), .rd_off(rd_off),
    .free_slot(free_slot), .full(full)
  );

  rxq_mem #(.AW(AW)) u_mem (
    .clk(clk), .we(wr_en), .be(4'b0001 << wr_off[1:0]),
    .waddr({wr_slot, wr_off[BW-1:2]}), .wbyte(wr_byte),
    .raddr({head, rd_off[BW-1:2]}), .rdata(mem_q)
  );

  logic [NUM_SRC-1:0] st_set, st_clr;
  always_comb begin
    st_set = '0;
    st_set[ST_RX_BIT]  = commit;
    st_set[ST_OVF_BIT] = ovf;
    st_clr = (reg_wr && reg_addr == A_STAT) ? reg_wdata[NUM_SRC-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status     <= '0;
      mask       <= '1;
      rx_en      <= 1'b0;
      irq        <= 1'b0;
      other_q    <= '0;
      sel_data_q <= 1'b0;
    end else begin
      status <= (status & ~st_clr) | st_set;
      if (reg_wr && reg_addr == A_MASK) mask  <= reg_wdata[NUM_SRC-1:0];
      if (reg_wr && reg_addr == A_CTRL) rx_en <= reg_wdata[0];
      irq        <= |(status & mask);
      sel_data_q <= pop_req;
      if (reg_rd) begin
        case (reg_addr)
          A_STAT:  other_q <= 32'(status);
          A_MASK:  other_q <= 32'(mask);
          A_CTRL:  other_q <= 32'(rx_en);
          A_CNT:   other_q <= 32'(pending);
          default: other_q <= '0;
        endcase
      end
    end
  end

  assign reg_rdata = sel_data_q ? mem_q : other_q;
endmodule

// File: rtl/eth_rx_frame_queue_chk.sv
module eth_rx_frame_queue_chk #(
  parameter int SLOTS = 31,
  parameter int CW    = 5,
  parameter int BW    = 7
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] pending,
  input logic [BW-1:0] rd_off,
  input logic          flush,
  input logic          commit,
  input logic          pop_req,
  input logic [6:0]    status,
  input logic [6:0]    mask,
  input logic          irq
);
  // R6
  pending_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(pending) <= SLOTS);

  // R5
  pending_step_chk: assert property (@(posedge clk) disable iff (rst)
    !flush |=> (int'(pending) == int'($past(pending)) ||
                int'(pending) == int'($past(pending)) + 1 ||
                int'(pending) + 1 == int'($past(pending))));

  // R5
  off_align_chk: assert property (@(posedge clk) disable iff (rst)
    rd_off[1:0] == 2'b00);

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (pending == '0 && rd_off == '0));

  // R7
  underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_req && pending == '0 && !commit && !flush) |=> (pending == '0 && rd_off == '0));

  // R9
  rx_status_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> status[0]);

  // R10
  masked_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> !irq);
endmodule

bind eth_rx_frame_queue eth_rx_frame_queue_chk #(.SLOTS(SLOTS), .CW(CW), .BW(BW)) u_chk (
  .clk(clk), .rst(rst), .pending(pending), .rd_off(rd_off), .flush(flush),
  .commit(commit), .pop_req(pop_req), .status(status), .mask(mask), .irq(irq)
);

// File: tb/eth_rx_frame_queue_tb.sv
module eth_rx_frame_queue_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS      = 31;
  localparam int SLOT_BYTES = 128;
  localparam int LIMIT      = SLOT_BYTES - 6;
  localparam logic [2:0] A_STAT = 3'd0, A_MASK = 3'd1, A_CTRL = 3'd2,
                         A_DATA = 3'd3, A_CNT  = 3'd4;

  logic clk = 1'b0, rst = 1'b1;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0;
  logic [7:0] rx_data = 0;
  logic [31:0] rx_crc = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_rx_frame_queue #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .rx_crc(rx_crc), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  bit model_en = 0;
  logic [31:0] exp_q[$];
  int fw_q[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 0;
  endtask

  function automatic logic [7:0] rec_byte(int i, int size, logic [7:0] fr[0:255], logic [31:0] crc);
    int tot = size + 6;
    if (i == 0) return tot[7:0];
    if (i == 1) return tot[15:8];
    if (i < size + 2) return fr[i-2];
    if (i < size + 6) return crc[8*(i-size-2) +: 8];
    return 8'h00;
  endfunction

  // returns 1 if the frame is expected to be stored
  task automatic send_frame(input int size, output bit stored);
    logic [7:0] fr [0:255];
    logic [31:0] crc;
    int nw;
    crc = $urandom;
    for (int k = 0; k < size; k++) fr[k] = 8'($urandom);
    for (int k = 0; k < size; k++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = (k == 0); rx_eof = (k == size - 1);
      rx_data = fr[k]; rx_crc = crc;
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0;
    repeat (16) @(negedge clk);
    stored = model_en && (fw_q.size() < SLOTS) && (size < LIMIT);
    if (stored) begin
      nw = (size + 6 + 3) / 4;
      for (int w = 0; w < nw; w++)
        exp_q.push_back({rec_byte(4*w+3, size, fr, crc), rec_byte(4*w+2, size, fr, crc),
                         rec_byte(4*w+1, size, fr, crc), rec_byte(4*w, size, fr, crc)});
      fw_q.push_back(nw);
    end
  endtask

  task automatic read_words(input int n, input string req);
    logic [31:0] v, e;
    for (int w = 0; w < n; w++) begin
      rd_reg(A_DATA, v);
      e = exp_q.pop_front();
      check(v === e, req, v, e);
    end
  endtask

  task automatic read_frame(input string req);
    int n;
    n = fw_q.pop_front();
    read_words(n, req);
  endtask

  task automatic check_count(input string req);
    logic [31:0] v;
    rd_reg(A_CNT, v);
    check(v === 32'(fw_q.size()), req, v, 32'(fw_q.size()));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    bit st;
    int n;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 R11 reset state and register map
    check(irq === 1'b0, "R1 irq", 32'(irq), 0);
    rd_reg(A_STAT, v); check(v === 0, "R1 status", v, 0);
    rd_reg(A_MASK, v); check(v === 32'h7F, "R1 R11 mask", v, 32'h7F);
    rd_reg(A_CTRL, v); check(v === 0, "R1 ctrl", v, 0);
    check_count("R1 count");

    // R2 disabled: frame dropped, no status
    send_frame(10, st);
    check_count("R2 disabled count");
    rd_reg(A_STAT, v); check(v === 0, "R2 no status", v, 0);

    wr_reg(A_CTRL, 1); model_en = 1;
    rd_reg(A_CTRL, v); check(v === 1, "R11 ctrl readback", v, 1);

    // R3 all padding cases
    for (int s = 1; s <= 5; s++) send_frame(s, st);
    check_count("R6 count five");
    rd_reg(A_STAT, v); check(v === 1, "R9 rx bit", v, 1);
    check(irq === 1'b1, "R10 irq high", 32'(irq), 1);
    for (int f = 0; f < 5; f++) read_frame("R3 R5 layout");
    check_count("R5 drained");

    // R9 write-1-to-clear
    wr_reg(A_STAT, 32'h7F);
    rd_reg(A_STAT, v); check(v === 0, "R9 clear", v, 0);
    check(irq === 1'b0, "R10 irq low", 32'(irq), 0);

    // R10 zero mask
    wr_reg(A_MASK, 0);
    send_frame(6, st);
    rd_reg(A_STAT, v); check(v === 1, "R9 rx bit masked", v, 1);
    check(irq === 1'b0, "R10 masked irq", 32'(irq), 0);
    wr_reg(A_MASK, 32'h7F);
    repeat (2) @(negedge clk);
    check(irq === 1'b1, "R10 unmasked irq", 32'(irq), 1);
    read_frame("R3 masked frame");
    wr_reg(A_STAT, 32'h7F);

    // R4 oversize boundary
    send_frame(LIMIT, st);
    check_count("R4 discard count");
    rd_reg(A_STAT, v); check(v === 32'h8, "R4 ovf bit", v, 32'h8);
    wr_reg(A_STAT, 32'h7F);
    send_frame(LIMIT - 1, st);
    check(st == 1, "R4 largest stored", 32'(st), 1);
    check_count("R4 largest count");
    read_frame("R4 largest layout");
    wr_reg(A_STAT, 32'h7F);

    // R7 underflow
    rd_reg(A_DATA, v); rd_reg(A_DATA, v);
    check_count("R7 count after underflow");
    send_frame(7, st);
    read_frame("R7 frame after underflow");

    // R6 fill ring, extra dropped
    for (int f = 0; f < SLOTS; f++) send_frame(1 + int'($urandom % 20), st);
    check_count("R6 full count");
    wr_reg(A_STAT, 32'h7F);
    send_frame(9, st);
    check(st == 0, "R2 full drop", 32'(st), 0);
    check_count("R2 full count");
    rd_reg(A_STAT, v); check(v === 0, "R2 full no status", v, 0);
    for (int f = 0; f < SLOTS; f++) read_frame("R6 ring order");
    check_count("R6 ring drained");

    // R8 flush mid-read
    for (int f = 0; f < 3; f++) send_frame(12, st);
    read_words(2, "R8 before flush");
    wr_reg(A_CTRL, 3);
    exp_q.delete(); fw_q.delete();
    check_count("R8 flushed count");
    send_frame(9, st);
    read_frame("R8 frame after flush");

    // random mix
    for (int it = 0; it < 150; it++) begin
      if (($urandom % 10) < 6) begin
        send_frame(1 + int'($urandom % 130), st);
      end else if (fw_q.size() > 0) begin
        read_frame("R3 R6 random");
      end
    end
    check_count("R5 random count");
    n = fw_q.size();
    for (int f = 0; f < n; f++) read_frame("R6 random drain");
    check_count("R5 random end");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule